// File: doc/BRIEF.md
# Coherency Unit Control Register Block

This block is the software-visible register file of the coherency controller in a small multicore cluster. A simple memory-mapped bus reaches it. Each access carries an address, write data, a write strobe, a read strobe and an access size given as a byte count. The block decodes only the low eight address bits, so it fills a 256-byte window that repeats across any wider address.

It holds four kinds of state. There is a one-bit enable. There is a read-only configuration word that is computed from the core-count parameter. There is a 32-bit per-core power status word that software may update one byte, halfword or word at a time. The remaining decoded offsets read as zero and ignore writes: the secure invalidate trigger, the two address filter registers and the two access-control registers. Every undecoded offset behaves the same way. Read data is registered and appears on the cycle after the read strobe.

Top module: `coh_unit_regs`

## Requirements
- R1: A write with a legal size to offset 0x00 stores bit 0 of the write data as the enable bit. A read of 0x00 returns that bit in bit 0, with bits 31:1 always zero.
- R2: Offset 0x04 reads as ((2^N - 1) << 4) | (N - 1), where N is the core-count parameter (1 to 4). With the default N = 4 the value is 0x000000F3. Writes to 0x04 change nothing.
- R3: A read at offset 0x08 + k, for k from 0 to 3, returns the power status word shifted right by 8*k bits, with zeros filled in from the top.
- R4: A write at offset 0x08 + k with size S replaces only the status bits under the S-byte mask shifted left by 8*k. The write data bits placed there come from the low S bytes of the write data. Every other status bit keeps its value.
- R5: When a shifted mask would extend past bit 31, it is truncated at bit 31 and does not wrap into the low bits. For example, a word write at 0x09 changes only bits 31:8.
- R6: The size field gives the byte count. The values 1, 2 and 4 are legal. A write with any other value (0, 3, 5, 6, 7) changes no state.
- R7: Offsets 0x0C, 0x40, 0x44, 0x50 and 0x54, and every other offset not named above, read as zero. Writes to them change no state.
- R8: Reset clears the enable bit, the power status word and the read data output to zero.
- R9: Read data is updated on the clock edge that samples the read strobe and holds its value while no read is made. Address bits above bit 7 are ignored, so an address of 0x708 reaches the same register as 0x08.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| bus_wdata | input | 32 | Write data, right-aligned for sub-word sizes |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data, valid the cycle after bus_re |

## Verification
The assertions assume that the bus inputs hold known values at every clock edge. They also assume that a cycle carries a read or a write but never both, since the read-back checks compare against the state as it stood before the edge. The stimulus keeps to this. It changes the inputs only on the falling edge and issues one access per cycle. It then drops both strobes and samples the result half a cycle after the edge that registered it.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int DW = 32;
  localparam int OFS_W = 8;

  localparam logic [OFS_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [OFS_W-1:0] OFS_CFG  = 8'h04;
  localparam logic [OFS_W-1:0] OFS_PWR  = 8'h08;

  typedef struct packed {
    logic       ctrl;
    logic       cfg;
    logic       pwr;
    logic [1:0] lane;
  } coh_sel_t;

  function automatic logic size_ok(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic logic [DW-1:0] base_mask(input logic [2:0] sz);
    logic [DW-1:0] m;
    case (sz)
      3'd1:    m = 32'h0000_00FF;
      3'd2:    m = 32'h0000_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [2:0] sz,
                                              input logic [1:0] lane);
    return base_mask(sz) << {lane, 3'b000};
  endfunction

  function automatic logic [DW-1:0] cfg_word(input int n);
    logic [DW-1:0] ones;
    ones = (32'd1 << n) - 32'd1;
    return (ones << 4) | DW'(n - 1);
  endfunction
endpackage

// File: rtl/coh_decode.sv
module coh_decode
  import coh_pkg::*;
(
  input  logic [OFS_W-1:0] ofs,
  output coh_sel_t         sel
);
  always_comb begin
    sel      = '0;
    sel.ctrl = (ofs == OFS_CTRL);
    sel.cfg  = (ofs == OFS_CFG);
    sel.pwr  = (ofs[OFS_W-1:2] == OFS_PWR[OFS_W-1:2]);
    sel.lane = ofs[1:0];
  end
endmodule

// File: rtl/coh_pwr_word.sv
module coh_pwr_word
  import coh_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    size,
  input  logic [1:0]    lane,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q,
  output logic [DW-1:0] mask
);
  logic [DW-1:0] data_sh;
  logic [DW-1:0] merged;

  always_comb begin
    mask    = lane_mask(size, lane);
    data_sh = (wdata & base_mask(size)) << {lane, 3'b000};
    merged  = (q & ~mask) | (data_sh & mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= merged;
  end
endmodule

// File: rtl/coh_rdmux.sv
module coh_rdmux
  import coh_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          re,
  input  coh_sel_t      sel,
  input  logic          ctrl_q,
  input  logic [DW-1:0] cfg_val,
  input  logic [DW-1:0] pwr_q,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] rd_next;

  always_comb begin
    if (sel.ctrl)     rd_next = {{(DW-1){1'b0}}, ctrl_q};
    else if (sel.cfg) rd_next = cfg_val;
    else if (sel.pwr) rd_next = pwr_q >> {sel.lane, 3'b000};
    else              rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rd_data <= '0;
    else if (re) rd_data <= rd_next;
  end
endmodule

// File: rtl/coh_unit_regs.sv
module coh_unit_regs
  import coh_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NCORE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [2:0]        bus_size,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       rd_data
);
  localparam logic [DW-1:0] CFG_VAL = cfg_word(NCORE);

  logic [OFS_W-1:0] ofs;
  logic             unused_addr_hi;
  coh_sel_t         sel;
  logic             wr_ok;
  logic             ctrl_wr;
  logic             pwr_wr;
  logic             ctrl_q;
  logic [DW-1:0]    pwr_q;
  logic [DW-1:0]    pwr_mask;

  assign ofs            = bus_addr[OFS_W-1:0];
  assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFS_W];
  assign wr_ok          = bus_we & size_ok(bus_size);
  assign ctrl_wr        = wr_ok & sel.ctrl;
  assign pwr_wr         = wr_ok & sel.pwr;

  coh_decode u_dec (
    .ofs (ofs),
    .sel (sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= 1'b0;
    else if (ctrl_wr) ctrl_q <= bus_wdata[0];
  end

  coh_pwr_word u_pwr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (pwr_wr),
    .size  (bus_size),
    .lane  (sel.lane),
    .wdata (bus_wdata),
    .q     (pwr_q),
    .mask  (pwr_mask)
  );

  coh_rdmux u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .re      (bus_re),
    .sel     (sel),
    .ctrl_q  (ctrl_q),
    .cfg_val (CFG_VAL),
    .pwr_q   (pwr_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/coh_unit_regs_chk.sv
module coh_unit_regs_chk #(
  parameter int NCORE = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  ofs,
  input logic        bus_we,
  input logic        bus_re,
  input logic [2:0]  bus_size,
  input logic [31:0] bus_wdata,
  input logic [31:0] rd_data,
  input logic        ctrl_q,
  input logic [31:0] pwr_q,
  input logic [31:0] pwr_mask
);
  localparam logic [31:0] CFG_EXP = 32'(((2 ** NCORE) - 1) * 16 + NCORE - 1);

  logic legal;
  logic at_pwr;
  logic at_live;
  assign legal   = (bus_size == 3'd1) || (bus_size == 3'd2) || (bus_size == 3'd4);
  assign at_pwr  = (ofs >= 8'h08) && (ofs <= 8'h0B);
  assign at_live = (ofs == 8'h00) || (ofs == 8'h04) || at_pwr;

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && legal && ofs == 8'h00) |=> (ctrl_q == $past(bus_wdata[0]))); // R1
  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && ofs == 8'h00) |=> (rd_data[31:1] == 31'd0)); // R1
  AST_CFG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && ofs == 8'h04) |=> (rd_data == CFG_EXP)); // R2
  AST_PWR_FULL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && ofs == 8'h08) |=> (rd_data == $past(pwr_q))); // R3
  AST_PWR_KEEP_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && legal && at_pwr) |=> (((pwr_q ^ $past(pwr_q)) & ~$past(pwr_mask)) == 32'd0)); // R4
  AST_BAD_SIZE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !legal) |=> ($stable(pwr_q) && $stable(ctrl_q))); // R6
  AST_RAZ_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !at_live) |=> (rd_data == 32'd0)); // R7
  AST_RAZ_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !at_live) |=> ($stable(pwr_q) && $stable(ctrl_q))); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(rd_data)); // R9
endmodule

bind coh_unit_regs coh_unit_regs_chk #(.NCORE(NCORE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ofs       (ofs),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_size  (bus_size),
  .bus_wdata (bus_wdata),
  .rd_data   (rd_data),
  .ctrl_q    (ctrl_q),
  .pwr_q     (pwr_q),
  .pwr_mask  (pwr_mask)
);

// File: tb/sim_coh_unit_regs.sv
`timescale 1ns/1ps
module sim_coh_unit_regs;
  localparam int ADDR_W = 12;
  localparam int NCORE  = 4;
  localparam int NVEC   = 36;
  localparam logic [1:0] OPW = 2'd1;
  localparam logic [1:0] OPR = 2'd2;
  // {op[76:75], size[74:72], addr[71:64], wdata[63:32], expected[31:0]}
  localparam logic [76:0] TBL [NVEC] = '{
    {OPW, 3'd4, 8'h00, 32'hFFFF_FFFF, 32'h0},          // R1
    {OPR, 3'd4, 8'h00, 32'h0,         32'h0000_0001},  // R1
    {OPW, 3'd1, 8'h00, 32'h0000_00FE, 32'h0},          // R1
    {OPR, 3'd4, 8'h00, 32'h0,         32'h0000_0000},  // R1
    {OPW, 3'd4, 8'h04, 32'h0000_0000, 32'h0},          // R2
    {OPR, 3'd4, 8'h04, 32'h0,         32'h0000_00F3},  // R2
    {OPW, 3'd4, 8'h08, 32'h1234_5678, 32'h0},          // R4
    {OPR, 3'd4, 8'h08, 32'h0,         32'h1234_5678},  // R3
    {OPR, 3'd1, 8'h09, 32'h0,         32'h0012_3456},  // R3
    {OPR, 3'd2, 8'h0A, 32'h0,         32'h0000_1234},  // R3
    {OPR, 3'd4, 8'h0B, 32'h0,         32'h0000_0012},  // R3
    {OPW, 3'd1, 8'h09, 32'h0000_00AB, 32'h0},          // R4
    {OPR, 3'd4, 8'h08, 32'h0,         32'h1234_AB78},  // R4
    {OPW, 3'd2, 8'h0A, 32'h9999_BEEF, 32'h0},          // R4
    {OPR, 3'd4, 8'h08, 32'h0,         32'hBEEF_AB78},  // R4
    {OPW, 3'd2, 8'h0B, 32'h0000_CDEF, 32'h0},          // R5
    {OPR, 3'd4, 8'h08, 32'h0,         32'hEFEF_AB78},  // R5
    {OPW, 3'd4, 8'h09, 32'h1122_3344, 32'h0},          // R5
    {OPR, 3'd4, 8'h08, 32'h0,         32'h2233_4478},  // R5
    {OPW, 3'd3, 8'h08, 32'h0000_0000, 32'h0},          // R6
    {OPR, 3'd4, 8'h08, 32'h0,         32'h2233_4478},  // R6
    {OPW, 3'd0, 8'h00, 32'h0000_0001, 32'h0},          // R6
    {OPR, 3'd4, 8'h00, 32'h0,         32'h0000_0000},  // R6
    {OPW, 3'd7, 8'h0A, 32'hFFFF_FFFF, 32'h0},          // R6
    {OPR, 3'd4, 8'h08, 32'h0,         32'h2233_4478},  // R6
    {OPW, 3'd4, 8'h0C, 32'hFFFF_FFFF, 32'h0},          // R7
    {OPR, 3'd4, 8'h0C, 32'h0,         32'h0000_0000},  // R7
    {OPW, 3'd4, 8'h40, 32'hFFFF_FFFF, 32'h0},          // R7
    {OPR, 3'd4, 8'h40, 32'h0,         32'h0000_0000},  // R7
    {OPW, 3'd4, 8'h44, 32'hFFFF_FFFF, 32'h0},          // R7
    {OPR, 3'd4, 8'h44, 32'h0,         32'h0000_0000},  // R7
    {OPW, 3'd4, 8'h50, 32'hFFFF_FFFF, 32'h0},          // R7
    {OPR, 3'd4, 8'h54, 32'h0,         32'h0000_0000},  // R7
    {OPR, 3'd4, 8'h05, 32'h0,         32'h0000_0000},  // R7
    {OPR, 3'd4, 8'h08, 32'h0,         32'h2233_4478},  // R7
    {OPR, 3'd4, 8'h00, 32'h0,         32'h0000_0000}   // R7
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [2:0]        bus_size = 3'd4;
  logic              bus_we = 1'b0;
  logic              bus_re = 1'b0;
  logic [31:0]       rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  coh_unit_regs #(.ADDR_W(ADDR_W), .NCORE(NCORE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size(bus_size), .bus_we(bus_we), .bus_re(bus_re), .rd_data(rd_data)
  );

  function automatic logic [31:0] cfg_expect(input int n);
    logic [31:0] v;
    v = 32'(n - 1);
    for (int i = 0; i < n; i++) v[4 + i] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // Drives one access at a falling edge; returns at the next falling edge.
  task automatic access(input logic [1:0] op, input logic [2:0] sz,
                        input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_size  = sz;
    bus_wdata = d;
    bus_we    = (op == OPW);
    bus_re    = (op == OPR);
    @(negedge clk);
    bus_we = 1'b0;
    bus_re = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset read data", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      access(TBL[i][76:75], TBL[i][74:72], {4'h0, TBL[i][71:64]}, TBL[i][63:32]);
      if (TBL[i][76:75] == OPR) check($sformatf("table[%0d]", i), rd_data, TBL[i][31:0]);
    end

    // R2: configuration value from a bench-side computation
    access(OPR, 3'd4, 12'h004, 32'h0);
    check("R2 config", rd_data, cfg_expect(NCORE));

    // R9: upper address bits ignored
    access(OPR, 3'd4, 12'h708, 32'h0);
    check("R9 alias 0x708", rd_data, 32'h2233_4478);
    access(OPW, 3'd1, 12'hF08, 32'h0000_00CC);
    access(OPR, 3'd4, 12'h008, 32'h0);
    check("R9 alias write", rd_data, 32'h2233_44CC);

    // R9: read data holds without strobe, updates on the strobe edge
    repeat (4) @(negedge clk);
    check("R9 hold", rd_data, 32'h2233_44CC);
    bus_addr = 12'h004; bus_re = 1'b1;
    @(posedge clk); #1;
    check("R9 latency", rd_data, cfg_expect(NCORE));
    @(negedge clk); bus_re = 1'b0;

    // R1 set enable then R8 reset clears everything
    access(OPW, 3'd2, 12'h000, 32'h0000_0003);
    access(OPR, 3'd4, 12'h000, 32'h0);
    check("R1 enable set", rd_data, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 rd_data cleared", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    access(OPR, 3'd4, 12'h000, 32'h0);
    check("R8 enable cleared", rd_data, 32'h0);
    access(OPR, 3'd4, 12'h008, 32'h0);
    check("R8 power cleared", rd_data, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule